// File: doc/BRIEF.md
# Per-Lane Enable, Squelch and Polarity Controller

This block sits between the control register space of a twelve-lane parallel optical module and its analog lane circuitry. It holds four per-lane control fields: lane deactivation, squelch defeat, polarity inversion and margin request. For each lane it merges them with live loss-of-signal and fault status into four final drive signals: lane off, output squelched, data inverted and margin active.

A mode input picks transmitter or receiver rules. In transmitter mode a deactivated lane, or a lane that reports a fault, is switched off. A fault is kept in a per-lane hold that outlives the fault condition. In receiver mode the lane is never switched off. A deactivated lane has its electrical output squelched instead, and fault status plays no part. In both modes a lane that loses its input is squelched unless squelch is defeated for that lane. A register-reset input returns every control field, and every fault hold, to its default. All drive outputs are registered. Each one settles on the clock edge that samples the input that caused it.

Top module: `lane_ctl`

## Requirements
- R1: Each lane's outputs depend only on that lane's control bits, loss-of-signal and fault inputs. A pattern written to one lane leaves the other lanes unchanged.
- R2: In either mode, a lane with loss of signal (`los` bit 1) and squelch not defeated (field 1 bit 0) has `squelched` at 1. With squelch defeated, loss of signal alone leaves `squelched` at 0.
- R3: In transmitter mode (`tx_mode`=1), a lane whose deactivation bit (field 0) is 1, or whose `fault` bit is 1, has `lane_off` at 1.
- R4: In transmitter mode, a fault keeps `lane_off` at 1 after the `fault` bit returns to 0. The hold ends only on a write to field 0, on `reg_rst` or on `rst`. A fault present in the same cycle as such a write sets the hold again.
- R5: In receiver mode (`tx_mode`=0), `lane_off` is 0 for every lane, `fault` has no effect, and a lane whose deactivation bit is 1 has `squelched` at 1.
- R6: `invert` for each lane equals that lane's bit in field 2.
- R7: `margin_on` for a lane is 1 only in transmitter mode, with that lane's field 3 bit at 1 and the lane not switched off. Otherwise it is 0.
- R8: `reg_rst`=1 returns all four fields and all fault holds to 0 on that edge. The default is lanes active, squelch not defeated, no inversion and margin off. `reg_rst` takes priority over a write in the same cycle.
- R9: While `rst`=1, all outputs are 0 and all fields and holds are cleared.
- R10: Every output changes on the first rising edge that samples the input that caused the change, including a field write.
- R11: A write (`cfg_we`=1) replaces the whole field chosen by `cfg_sel`: 0 deactivation, 1 squelch defeat, 2 inversion, 3 margin. Bit i of `cfg_wdata` goes to lane i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rst | input | 1 | Return control fields and fault holds to defaults |
| tx_mode | input | 1 | 1 selects transmitter rules, 0 selects receiver rules |
| cfg_we | input | 1 | Field write strobe |
| cfg_sel | input | 2 | Field select for the write |
| cfg_wdata | input | 12 | New field contents, one bit per lane |
| los | input | 12 | Live per-lane loss of signal |
| fault | input | 12 | Live per-lane fault |
| lane_off | output | 12 | Lane switched off |
| squelched | output | 12 | Lane output squelched |
| invert | output | 12 | Lane data polarity inverted |
| margin_on | output | 12 | Lane in margin mode |

## Verification
The assertions assume that `tx_mode`, `los` and `fault` are sampled synchronous levels. They also assume a change of `tx_mode` needs no extra settling: the rules of the new mode apply from the next edge. The bench drives all inputs on falling edges, so every rising edge sees stable levels. It toggles the mode only between steps whose expected values are computed for that mode.

// File: rtl/lanectl_pkg.sv
package lanectl_pkg;
  typedef enum logic [1:0] {
    FLD_OFF   = 2'd0,
    FLD_SQDEF = 2'd1,
    FLD_INV   = 2'd2,
    FLD_MRG   = 2'd3
  } fld_e;
  localparam int NFLD = 4;
endpackage

// File: rtl/lanectl_cfg_regs.sv
module lanectl_cfg_regs
  import lanectl_pkg::*;
#(
  parameter int N = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_rst,
  input  logic                      we,
  input  logic [1:0]                sel,
  input  logic [N-1:0]              wdata,
  output logic [NFLD-1:0][N-1:0]    fld_nxt,
  output logic [NFLD-1:0][N-1:0]    fld_q,
  output logic                      hold_clr
);
  for (genvar f = 0; f < NFLD; f++) begin : g_fld
    always_comb begin
      if (reg_rst)
        fld_nxt[f] = '0;
      else if (we && (sel == f[1:0]))
        fld_nxt[f] = wdata;
      else
        fld_nxt[f] = fld_q[f];
    end
    always_ff @(posedge clk) begin
      if (rst) fld_q[f] <= '0;
      else     fld_q[f] <= fld_nxt[f];
    end
  end
  assign hold_clr = reg_rst || (we && (sel == FLD_OFF));
endmodule

// File: rtl/lanectl_fault_hold.sv
module lanectl_fault_hold #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reg_rst,
  input  logic         clr,
  input  logic         tx_mode,
  input  logic [N-1:0] fault,
  output logic [N-1:0] hold_nxt
);
  logic [N-1:0] hold_q;
  for (genvar i = 0; i < N; i++) begin : g_lane
    always_comb begin
      if (reg_rst)
        hold_nxt[i] = 1'b0;
      else
        hold_nxt[i] = (hold_q[i] && !clr) || (tx_mode && fault[i]);
    end
    always_ff @(posedge clk) begin
      if (rst) hold_q[i] <= 1'b0;
      else     hold_q[i] <= hold_nxt[i];
    end
  end
endmodule

// File: rtl/lanectl_lane_mux.sv
module lanectl_lane_mux #(
  parameter int N = 12
) (
  input  logic         tx_mode,
  input  logic [N-1:0] deact,
  input  logic [N-1:0] sqdef,
  input  logic [N-1:0] inv,
  input  logic [N-1:0] mrg,
  input  logic [N-1:0] hold,
  input  logic [N-1:0] fault,
  input  logic [N-1:0] los,
  output logic [N-1:0] off_d,
  output logic [N-1:0] sq_d,
  output logic [N-1:0] inv_d,
  output logic [N-1:0] mrg_d
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    logic los_sq;
    assign los_sq = los[i] && !sqdef[i];
    always_comb begin
      if (tx_mode) begin
        off_d[i] = deact[i] || hold[i] || fault[i];
        sq_d[i]  = los_sq;
        mrg_d[i] = mrg[i] && !off_d[i];
      end else begin
        off_d[i] = 1'b0;
        sq_d[i]  = los_sq || deact[i];
        mrg_d[i] = 1'b0;
      end
      inv_d[i] = inv[i];
    end
  end
endmodule

// File: rtl/lane_ctl.sv
module lane_ctl
  import lanectl_pkg::*;
#(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reg_rst,
  input  logic         tx_mode,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_sel,
  input  logic [N-1:0] cfg_wdata,
  input  logic [N-1:0] los,
  input  logic [N-1:0] fault,
  output logic [N-1:0] lane_off,
  output logic [N-1:0] squelched,
  output logic [N-1:0] invert,
  output logic [N-1:0] margin_on
);
  logic [NFLD-1:0][N-1:0] fld_nxt;
  logic [NFLD-1:0][N-1:0] fld_q;
  logic                   hold_clr;
  logic [N-1:0]           hold_nxt;
  logic [N-1:0]           off_d, sq_d, inv_d, mrg_d;
  logic [N-1:0]           deact_q, sqdef_q;

  lanectl_cfg_regs #(.N(N)) u_regs (
    .clk(clk), .rst(rst), .reg_rst(reg_rst), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .fld_nxt(fld_nxt), .fld_q(fld_q), .hold_clr(hold_clr)
  );

  lanectl_fault_hold #(.N(N)) u_hold (
    .clk(clk), .rst(rst), .reg_rst(reg_rst), .clr(hold_clr),
    .tx_mode(tx_mode), .fault(fault), .hold_nxt(hold_nxt)
  );

  lanectl_lane_mux #(.N(N)) u_mux (
    .tx_mode(tx_mode),
    .deact(fld_nxt[int'(FLD_OFF)]), .sqdef(fld_nxt[int'(FLD_SQDEF)]),
    .inv(fld_nxt[int'(FLD_INV)]), .mrg(fld_nxt[int'(FLD_MRG)]),
    .hold(hold_nxt), .fault(fault), .los(los),
    .off_d(off_d), .sq_d(sq_d), .inv_d(inv_d), .mrg_d(mrg_d)
  );

  assign deact_q = fld_q[int'(FLD_OFF)];
  assign sqdef_q = fld_q[int'(FLD_SQDEF)];

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_off  <= '0;
      squelched <= '0;
      invert    <= '0;
      margin_on <= '0;
    end else begin
      lane_off  <= off_d;
      squelched <= sq_d;
      invert    <= inv_d;
      margin_on <= mrg_d;
    end
  end
endmodule

// File: rtl/lanectl_chk.sv
module lanectl_chk #(
  parameter int N = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         reg_rst,
  input logic         tx_mode,
  input logic [N-1:0] los,
  input logic [N-1:0] fault,
  input logic [N-1:0] lane_off,
  input logic [N-1:0] squelched,
  input logic [N-1:0] invert,
  input logic [N-1:0] margin_on,
  input logic [N-1:0] deact_q,
  input logic [N-1:0] sqdef_q
);
  a_r2_los_squelch: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(los) & ~sqdef_q) & ~squelched) == '0));

  a_r3_tx_fault_off: assert property (@(posedge clk) disable iff (rst)
    tx_mode |=> ((lane_off & $past(fault)) == $past(fault)));

  a_r5_rx_never_off: assert property (@(posedge clk) disable iff (rst)
    !tx_mode |=> (lane_off == '0));

  a_r5_rx_deact_squelch: assert property (@(posedge clk) disable iff (rst)
    !tx_mode |=> ((deact_q & ~squelched) == '0));

  a_r7_margin_needs_on: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((margin_on & lane_off) == '0));

  a_r8_regrst_defaults: assert property (@(posedge clk) disable iff (rst)
    reg_rst |=> (invert == '0 && margin_on == '0));
endmodule

bind lane_ctl lanectl_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .reg_rst(reg_rst), .tx_mode(tx_mode), .los(los),
  .fault(fault), .lane_off(lane_off), .squelched(squelched), .invert(invert),
  .margin_on(margin_on), .deact_q(deact_q), .sqdef_q(sqdef_q)
);

// File: tb/tb_lane_ctl.sv
`timescale 1ns/1ps
module tb_lane_ctl;
  localparam int N = 12;
  logic clk = 1'b0;
  logic rst, reg_rst, tx_mode, cfg_we;
  logic [1:0] cfg_sel;
  logic [N-1:0] cfg_wdata, los, fault;
  logic [N-1:0] lane_off, squelched, invert, margin_on;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  lane_ctl #(.N(N)) dut (
    .clk(clk), .rst(rst), .reg_rst(reg_rst), .tx_mode(tx_mode),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .los(los), .fault(fault), .lane_off(lane_off), .squelched(squelched),
    .invert(invert), .margin_on(margin_on)
  );

  // {tx, los, fault, exp_off, exp_sq}; config deact=003 sqdef=0F0 inv=A5A mrg=FFF
  localparam logic [48:0] VEC [6] = '{
    {1'b1, 12'h000, 12'h000, 12'h003, 12'h000},
    {1'b1, 12'hFFF, 12'h000, 12'h003, 12'hF0F},
    {1'b0, 12'h000, 12'h000, 12'h000, 12'h003},
    {1'b0, 12'hFFF, 12'hFFF, 12'h000, 12'hF0F},
    {1'b0, 12'h0F0, 12'h000, 12'h000, 12'h003},
    {1'b1, 12'h00F, 12'h000, 12'h003, 12'h00F}
  };

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [N-1:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; reg_rst = 1'b0; tx_mode = 1'b1; cfg_we = 1'b0;
    cfg_sel = '0; cfg_wdata = '0; los = '1; fault = '1;
    @(negedge clk); step();
    check("R9 off", lane_off, '0);
    check("R9 sq", squelched, '0);
    check("R9 mrg", margin_on, '0);
    rst = 1'b0; los = '0; fault = '0;
    step();

    wr(2'd2, 12'h001);                       // R1, R10
    check("R10 invert same edge", invert, 12'h001);
    check("R1 single lane", invert, 12'h001);
    wr(2'd0, 12'h003);
    wr(2'd1, 12'h0F0);
    wr(2'd2, 12'hA5A);
    wr(2'd3, 12'hFFF);
    check("R6 invert", invert, 12'hA5A);
    check("R11 field0", lane_off, 12'h003);
    check("R7 margin tx", margin_on, 12'hFFC);

    for (int k = 0; k < 6; k++) begin
      tx_mode = VEC[k][48]; los = VEC[k][47:36]; fault = VEC[k][35:24];
      step();
      check(VEC[k][48] ? "R3 vec off" : "R5 vec off", lane_off, VEC[k][23:12]);
      check("R2 vec sq", squelched, VEC[k][11:0]);
      check("R7 vec mrg", margin_on, VEC[k][48] ? (12'hFFF & ~VEC[k][23:12]) : 12'h000);
      check("R6 vec inv", invert, 12'hA5A);
    end

    tx_mode = 1'b1; los = '0; fault = 12'h020;
    step();
    check("R3 live fault", lane_off, 12'h023);
    fault = '0;
    step();
    check("R4 hold", lane_off, 12'h023);
    step();
    check("R4 hold again", lane_off, 12'h023);
    wr(2'd0, 12'h003);
    check("R4 clear by write", lane_off, 12'h003);

    fault = 12'h400;
    step();
    fault = '0;
    reg_rst = 1'b1; cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 12'hFFF; los = 12'hFFF;
    step();
    reg_rst = 1'b0; cfg_we = 1'b0;
    check("R8 off", lane_off, '0);
    check("R8 inv over write", invert, '0);
    check("R8 mrg", margin_on, '0);
    check("R8 sq default", squelched, 12'hFFF);

    tx_mode = 1'b0; fault = 12'hFFF; los = '0;
    step();
    check("R5 fault ignored", lane_off, '0);
    check("R5 no sq", squelched, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule